// File: doc/BRIEF.md
# Front-Panel Display and Keypad Scanner

This block sits on a small CPU register port and drives a multiplexed front panel. The panel has a row of sixteen segmented characters, of which one is lit at a time, and a keypad of six columns with four buttons each. Software refreshes the display by stepping a character pointer across the row and writing a segment pattern for each position in turn. It steps the pointer with read strobes: one offset returns the pointer to the leftmost position, one moves it one place to the right, and one blanks the segments so the move does not ghost onto the neighbour.

The keypad shares the scan. While one of the six leftmost characters is active, the keypad column with the same index is driven. A read of the key offset returns the four buttons of that column, active low. Debouncing, LED drive and refresh pacing are left to software and board logic.

Top module: `panel_scan_top`

## Requirements
- R1: After synchronous reset the active position is 0 (`char_sel` = 1), `seg_out` is all zeros, `col_drv` selects column 0 and `bus_rdata` is 16'hFFFF.
- R2: A read strobe at offset 0 makes position 0 active on the following cycle, whatever the previous position.
- R3: A read strobe at offset 1 moves the active position one place to the right on the following cycle; from position 15 it wraps to 0.
- R4: `char_sel` is one-hot at all times, with bit n set when position n is active.
- R5: A write strobe at offset 0 loads `bus_wdata` (15 bits, bit 0 = segment 0, a 1 lights the segment) into `seg_out` on the following cycle. Writing zero blanks the character.
- R6: A read strobe at offset 2 clears `seg_out` to all zeros on the following cycle and leaves the position unchanged.
- R7: Write strobes at offsets 1, 2 and 3 have no effect on `seg_out`, the position or `bus_rdata`.
- R8: `col_drv` bit k is high exactly when position k is active, for k = 0 to 5. No column is driven at positions 6 to 15.
- R9: A read strobe at offset 3 returns the 4 buttons of the driven column in `bus_rdata` bits 3:0 on the following cycle (bit 0 = top button, 0 = pressed), with bits 15:4 set to ones. At positions 6 to 15 the whole word reads 16'hFFFF.
- R10: A read strobe at offset 0, 1 or 2 returns 16'hFFFF in `bus_rdata`. `bus_rdata` holds its value between read strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 15 | Write data, segment pattern lanes |
| bus_rdata | output | 16 | Registered read data |
| char_sel | output | 16 | One-hot active character position |
| seg_out | output | 15 | Segment pattern of the active character |
| col_drv | output | 6 | Keypad column drive, active high |
| btn_n | input | 4 | Button return lines of the driven column, active low |

## Verification
The bench builds the block with its default sizes: sixteen positions, six keypad columns, four rows and fifteen segments. With sixteen positions a run of twenty advance strobes crosses the wrap from 15 to 0, and every position is visited with a key read, so both the six column-driving positions and the ten silent ones are compared. Segment loads with the top lane set and cleared, blanking reads and ignored writes at every other offset are checked against the same cycle-accurate model.

// File: rtl/panel_scan_pkg.sv
package panel_scan_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    OFS_HOME  = 2'd0,
    OFS_STEP  = 2'd1,
    OFS_BLANK = 2'd2,
    OFS_KEYS  = 2'd3
  } panel_ofs_e;
endpackage

// File: rtl/panel_pos_counter.sv
module panel_pos_counter #(
  parameter int NUM_POS  = 16,
  parameter int NUM_COLS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                home,
  input  logic                step,
  output logic [NUM_POS-1:0]  sel,
  output logic [NUM_COLS-1:0] cols
);
  localparam int PW = $clog2(NUM_POS);

  logic [PW-1:0]       pos_q;
  logic [PW-1:0]       pos_d;
  logic [NUM_POS-1:0]  sel_d;
  logic [NUM_COLS-1:0] cols_d;

  always_comb begin
    pos_d = pos_q;
    if (home)
      pos_d = '0;
    else if (step)
      pos_d = (pos_q == PW'(NUM_POS - 1)) ? '0 : pos_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_POS; i++) begin : g_sel
    assign sel_d[i] = (pos_d == PW'(i));
  end

  for (genvar k = 0; k < NUM_COLS; k++) begin : g_col
    assign cols_d[k] = sel_d[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      sel   <= NUM_POS'(1);
      cols  <= NUM_COLS'(1);
    end else begin
      pos_q <= pos_d;
      sel   <= sel_d;
      cols  <= cols_d;
    end
  end
endmodule

// File: rtl/panel_seg_latch.sv
module panel_seg_latch #(
  parameter int SEG_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             blank,
  input  logic [SEG_W-1:0] din,
  output logic [SEG_W-1:0] seg
);
  always_ff @(posedge clk) begin
    if (rst)
      seg <= '0;
    else if (blank)
      seg <= '0;
    else if (load)
      seg <= din;
  end
endmodule

// File: rtl/panel_key_reader.sv
module panel_key_reader #(
  parameter int NUM_COLS = 6,
  parameter int ROWS     = 4,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_any,
  input  logic                rd_keys,
  input  logic [NUM_COLS-1:0] cols,
  input  logic [ROWS-1:0]     btn_n,
  output logic [DATA_W-1:0]   rdata
);
  localparam int PAD_W = DATA_W - ROWS;

  logic              col_live;
  logic [ROWS-1:0]   rows_seen;

  assign col_live  = |cols;
  assign rows_seen = col_live ? btn_n : '1;

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '1;
    else if (rd_any)
      rdata <= rd_keys ? {{PAD_W{1'b1}}, rows_seen} : '1;
  end
endmodule

// File: rtl/panel_scan_top.sv
module panel_scan_top
  import panel_scan_pkg::*;
#(
  parameter int NUM_POS  = 16,
  parameter int NUM_COLS = 6,
  parameter int ROWS     = 4,
  parameter int SEG_W    = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [SEG_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_POS-1:0]  char_sel,
  output logic [SEG_W-1:0]    seg_out,
  output logic [NUM_COLS-1:0] col_drv,
  input  logic [ROWS-1:0]     btn_n
);
  panel_ofs_e ofs;
  logic       rd_home, rd_step, rd_blank, rd_keys, wr_seg;

  assign ofs      = panel_ofs_e'(bus_addr);
  assign rd_home  = bus_rd && (ofs == OFS_HOME);
  assign rd_step  = bus_rd && (ofs == OFS_STEP);
  assign rd_blank = bus_rd && (ofs == OFS_BLANK);
  assign rd_keys  = bus_rd && (ofs == OFS_KEYS);
  assign wr_seg   = bus_wr && (ofs == OFS_HOME);

  panel_pos_counter #(.NUM_POS(NUM_POS), .NUM_COLS(NUM_COLS)) u_pos (
    .clk  (clk),
    .rst  (rst),
    .home (rd_home),
    .step (rd_step),
    .sel  (char_sel),
    .cols (col_drv)
  );

  panel_seg_latch #(.SEG_W(SEG_W)) u_seg (
    .clk   (clk),
    .rst   (rst),
    .load  (wr_seg),
    .blank (rd_blank),
    .din   (bus_wdata),
    .seg   (seg_out)
  );

  panel_key_reader #(.NUM_COLS(NUM_COLS), .ROWS(ROWS), .DATA_W(DATA_W)) u_key (
    .clk     (clk),
    .rst     (rst),
    .rd_any  (bus_rd),
    .rd_keys (rd_keys),
    .cols    (col_drv),
    .btn_n   (btn_n),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/panel_scan_chk.sv
module panel_scan_chk #(
  parameter int NUM_POS  = 16,
  parameter int NUM_COLS = 6,
  parameter int SEG_W    = 15,
  parameter int ADDR_W   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [SEG_W-1:0]    bus_wdata,
  input logic [NUM_POS-1:0]  char_sel,
  input logic [SEG_W-1:0]    seg_out,
  input logic [NUM_COLS-1:0] col_drv
);
  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(char_sel) == 1);

  assert_home_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd0) |=> char_sel[0]);

  assert_step_rotate_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd1) |=>
      char_sel == {$past(char_sel[NUM_POS-2:0]), $past(char_sel[NUM_POS-1])});

  assert_seg_load_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0) |=> seg_out == $past(bus_wdata));

  assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd2) |=> seg_out == '0);

  assert_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != 2'd0 && !(bus_rd && bus_addr == 2'd2)) |=> $stable(seg_out));

  assert_col_follows_R8: assert property (@(posedge clk) disable iff (rst)
    col_drv == char_sel[NUM_COLS-1:0]);
endmodule

bind panel_scan_top panel_scan_chk #(
  .NUM_POS(NUM_POS), .NUM_COLS(NUM_COLS), .SEG_W(SEG_W), .ADDR_W(2)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .char_sel(char_sel), .seg_out(seg_out), .col_drv(col_drv)
);

// File: tb/sim_panel_scan_top.sv
`timescale 1ns/1ps
module sim_panel_scan_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [14:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] char_sel;
  logic [14:0] seg_out;
  logic [5:0]  col_drv;
  logic [3:0]  btn_n = 4'hF;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int          m_pos;
  logic [14:0] m_seg;
  logic [15:0] m_rd;

  always #2 clk = ~clk;

  panel_scan_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .char_sel(char_sel),
    .seg_out(seg_out), .col_drv(col_drv), .btn_n(btn_n)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [15:0] sel_e = 16'(1) << m_pos;
    logic [15:0] col_e = (m_pos < 6) ? (16'(1) << m_pos) : 16'h0;
    check(tag, "char_sel", char_sel, sel_e);
    check(tag, "col_drv", {10'h0, col_drv}, col_e);
    check(tag, "seg_out", {1'b0, seg_out}, {1'b0, m_seg});
    check(tag, "bus_rdata", bus_rdata, m_rd);
  endtask

  // one bus cycle: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [14:0] d, input logic [3:0] b, input string tag);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; btn_n = b;
    @(posedge clk);
    if (rd && a == 2'd3)      m_rd = (m_pos < 6) ? {12'hFFF, b} : 16'hFFFF;
    else if (rd)              m_rd = 16'hFFFF;
    if (wr && a == 2'd0)      m_seg = d;
    if (rd && a == 2'd2)      m_seg = '0;
    if (rd && a == 2'd0)      m_pos = 0;
    else if (rd && a == 2'd1) m_pos = (m_pos + 1) % 16;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    m_pos = 0; m_seg = '0; m_rd = 16'hFFFF;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst = 1'b0;
    step(0, 0, 2'd0, 15'h0, 4'hF, "R1");

    // segment loads, top lane set and clear patterns
    step(0, 1, 2'd0, 15'h7ABC, 4'hF, "R5");
    step(0, 1, 2'd0, 15'h0155, 4'hF, "R5");
    // writes at other offsets leave everything alone
    step(0, 1, 2'd1, 15'h1234, 4'hF, "R7");
    step(0, 1, 2'd2, 15'h7FFF, 4'hF, "R7");
    step(0, 1, 2'd3, 15'h0F0F, 4'hF, "R7");
    // blanking by read and by writing zero
    step(1, 0, 2'd2, 15'h0, 4'hF, "R6");
    step(0, 1, 2'd0, 15'h4001, 4'hF, "R5");
    step(0, 1, 2'd0, 15'h0000, 4'hF, "R5");
    // rdata holds between reads
    step(1, 0, 2'd3, 15'h0, 4'b1010, "R9");
    step(0, 0, 2'd3, 15'h0, 4'b0000, "R10");

    // walk across the row with a key read at every position, past the wrap
    for (int i = 0; i < 20; i++) begin
      logic [3:0] pat = 4'(i * 5 + 3);
      step(1, 0, 2'd3, 15'h0, pat, (m_pos < 6) ? "R9" : "R8");
      step(0, 1, 2'd0, 15'(i * 1111), pat, "R5");
      step(1, 0, 2'd2, 15'h0, pat, "R6");
      step(1, 0, 2'd1, 15'h0, pat, (m_pos == 15) ? "R3" : "R4");
    end

    // home from mid-row, then strobe reads return all ones
    step(1, 0, 2'd0, 15'h0, 4'h0, "R2");
    step(1, 0, 2'd3, 15'h0, 4'b0110, "R9");
    step(1, 0, 2'd1, 15'h0, 4'h0, "R10");
    step(1, 0, 2'd1, 15'h0, 4'h0, "R3");
    step(1, 0, 2'd3, 15'h0, 4'b0011, "R9");
    step(1, 0, 2'd2, 15'h0, 4'h0, "R10");
    // home and segment load in one cycle at offset 0
    step(1, 1, 2'd0, 15'h2AAA, 4'hF, "R2");
    step(1, 0, 2'd3, 15'h0, 4'b1110, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule